// File: doc/BRIEF.md
# Reset Source Controller with Supply Monitor

This block folds four reset causes into a single system reset output: an active-low external reset pin, a supply-monitor comparator, a one-cycle software reset strobe and the power-on reset (the block's own asynchronous reset `rst_ni`). It records which cause produced the most recent reset so that software can read it back after the system restarts.

Two byte-wide registers sit behind a small write port and a combinational read port, with `reg_sel_i` choosing between them. The monitor register holds the supply-monitor enable and shows the live, settled supply status. The source register holds the monitor-select bit and the one-hot cause flags. The comparator is a digital input that is forced low for a settling period after the monitor is enabled.

Reset exit is stretched by a programmable number of cycles for pin, software and power-on causes. A monitor-caused reset releases as soon as the supply is seen good again. The monitor enable and select bits survive every reset except power-on.

Top module: `rst_src_ctrl`

## Requirements
- R1: `ext_rst_ni` and `vmon_cmp_i` each pass through two flip-flops before use. A low pin raises `sys_rst_o` on the third rising edge, and `sys_rst_o` stays high while the pin stays low.
- R2: After a pin, software or power-on cause goes away, `sys_rst_o` stays high for exactly `STRETCH_CYC` further cycles (default 16). While `rst_ni` is low, `sys_rst_o` is high.
- R3: Monitor register (`reg_sel_i`=0) layout: bit 7 is the monitor enable (read/write) and bit 6 is the read-only status. Bits 5:0 read 0 and ignore writes. Status is 1 only when the monitor is enabled, has settled, and the synchronized comparator is high (supply above threshold).
- R4: After the enable is set, the status reads 0 for `SETTLE_CYC` cycles (default 8), whatever the comparator does.
- R5: The monitor causes a reset only when it is both enabled and selected. Select is bit 1 of the source register (`reg_sel_i`=1).
- R6: With the monitor enabled and selected, a status of 0 holds the system in reset. Selecting it before it has settled therefore causes a reset. Selecting it after settling, with the supply good, causes none.
- R7: A monitor-caused reset releases on the cycle after the status returns to 1, with no stretch.
- R8: On every reset exit, exactly one cause flag in the source register is set and the others are cleared. Bit 0 is pin, bit 2 is monitor, bit 3 is software and bit 4 is power-on. Bits 7:5 read 0.
- R9: The monitor enable and select bits keep their values through pin, software and monitor resets. Power-on clears both.
- R10: A one-cycle `sw_rst_i` pulse while the system is running starts a stretched reset.
- R11: When causes arrive together, the pin outranks the monitor, and the monitor outranks software. A pin assertion during the stretch restarts the reset with the pin as cause.
- R12: Register writes are ignored while `sys_rst_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_ni | input | 1 | External reset pin, active low, asynchronous to clk_i |
| vmon_cmp_i | input | 1 | Supply comparator, 1 = above threshold |
| sw_rst_i | input | 1 | Software reset strobe |
| reg_we_i | input | 1 | Register write enable |
| reg_sel_i | input | 1 | 0 = monitor register, 1 = source register |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| sys_rst_o | output | 1 | System reset, active high |

## Verification
The hardest case to reach is a monitor reset that software triggers itself by selecting the monitor before it has settled. The bench sets the enable and the select bit in two consecutive writes, so the select lands inside the settling window. It then watches the reset release without a stretch once settling ends. Overlapping causes are reached the same way:
- a software strobe issued in the same cycle as a pin assertion,
- a pin assertion placed inside a running stretch,
- register writes issued while a pin reset is in force.

A behavioural model compares `sys_rst_o` and the read data on every cycle.

// File: rtl/rst_src_pkg.sv
package rst_src_pkg;
  typedef enum logic [1:0] {CAUSE_POR, CAUSE_PIN, CAUSE_MON, CAUSE_SW} cause_e;
  typedef enum logic [1:0] {SEQ_RUN, SEQ_HOLD, SEQ_STRETCH} seq_e;
  localparam int unsigned REG_W = 8;
  // flag vector order {por, sw, mon, pin}
  localparam int unsigned FLAG_W = 4;

  function automatic logic [FLAG_W-1:0] cause_flag(cause_e c);
    logic [FLAG_W-1:0] f;
    f = '0;
    case (c)
      CAUSE_PIN: f[0] = 1'b1;
      CAUSE_MON: f[1] = 1'b1;
      CAUSE_SW:  f[2] = 1'b1;
      default:   f[3] = 1'b1;
    endcase
    return f;
  endfunction
endpackage

// File: rtl/rst_sync2.sv
module rst_sync2 #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/vmon_settle.sv
module vmon_settle #(
  parameter int unsigned SETTLE_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic cmp_i,
  output logic ok_o
);
  localparam int unsigned CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!en_i)        cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  // comparator output is forced low until settled
  assign ok_o = en_i && (cnt_q == LAST) && cmp_i;
endmodule

// File: rtl/rst_seq.sv
module rst_seq
  import rst_src_pkg::*;
#(
  parameter int unsigned STRETCH_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_act_i,
  input  logic              mon_req_i,
  input  logic              sw_req_i,
  output logic              sys_rst_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int unsigned CW = (STRETCH_CYC > 1) ? $clog2(STRETCH_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(STRETCH_CYC - 1);

  seq_e              state_q;
  cause_e            cause_q;
  logic [CW-1:0]     cnt_q;
  logic [FLAG_W-1:0] flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_STRETCH;
      cause_q <= CAUSE_POR;
      cnt_q   <= '0;
      flags_q <= '0;
    end else begin
      case (state_q)
        SEQ_RUN: begin
          cnt_q <= '0;
          if (pin_act_i) begin
            state_q <= SEQ_HOLD;
            cause_q <= CAUSE_PIN;
          end else if (mon_req_i) begin
            state_q <= SEQ_HOLD;
            cause_q <= CAUSE_MON;
          end else if (sw_req_i) begin
            state_q <= SEQ_STRETCH;
            cause_q <= CAUSE_SW;
          end
        end
        SEQ_HOLD: begin
          cnt_q <= '0;
          if (cause_q == CAUSE_PIN) begin
            if (!pin_act_i) state_q <= SEQ_STRETCH;
          end else if (pin_act_i) begin
            cause_q <= CAUSE_PIN;
          end else if (!mon_req_i) begin
            state_q <= SEQ_RUN;          // no stretch after monitor reset
            flags_q <= cause_flag(cause_q);
          end
        end
        default: begin
          if (pin_act_i) begin
            state_q <= SEQ_HOLD;
            cause_q <= CAUSE_PIN;
            cnt_q   <= '0;
          end else if (cnt_q == LAST) begin
            state_q <= SEQ_RUN;
            flags_q <= cause_flag(cause_q);
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign sys_rst_o = (state_q != SEQ_RUN);
  assign flags_o   = flags_q;
endmodule

// File: rtl/rst_src_ctrl.sv
module rst_src_ctrl
  import rst_src_pkg::*;
#(
  parameter int unsigned STRETCH_CYC = 16,
  parameter int unsigned SETTLE_CYC  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_rst_ni,
  input  logic             vmon_cmp_i,
  input  logic             sw_rst_i,
  input  logic             reg_we_i,
  input  logic             reg_sel_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             sys_rst_o
);
  localparam int unsigned EN_BIT  = 7;
  localparam int unsigned ST_BIT  = 6;
  localparam int unsigned SEL_BIT = 1;

  logic              pin_s, cmp_s;
  logic              mon_en_q, mon_sel_q;
  logic              mon_ok, mon_req, wr_ok;
  logic [FLAG_W-1:0] flags;
  logic              unused_wdata;

  rst_sync2 #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({vmon_cmp_i, ext_rst_ni}),
    .q_o   ({cmp_s, pin_s})
  );

  vmon_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (mon_en_q),
    .cmp_i (cmp_s),
    .ok_o  (mon_ok)
  );

  assign mon_req = mon_en_q && mon_sel_q && !mon_ok;

  rst_seq #(.STRETCH_CYC(STRETCH_CYC)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_act_i(!pin_s),
    .mon_req_i(mon_req),
    .sw_req_i (sw_rst_i),
    .sys_rst_o(sys_rst_o),
    .flags_o  (flags)
  );

  assign wr_ok = reg_we_i && !sys_rst_o;

  // enable and select are cleared by power-on only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mon_en_q  <= 1'b0;
      mon_sel_q <= 1'b0;
    end else if (wr_ok) begin
      if (!reg_sel_i) mon_en_q  <= reg_wdata_i[EN_BIT];
      else            mon_sel_q <= reg_wdata_i[SEL_BIT];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (!reg_sel_i) begin
      reg_rdata_o[EN_BIT] = mon_en_q;
      reg_rdata_o[ST_BIT] = mon_ok;
    end else begin
      reg_rdata_o[0]       = flags[0];
      reg_rdata_o[SEL_BIT] = mon_sel_q;
      reg_rdata_o[4:2]     = flags[3:1];
    end
  end

  assign unused_wdata = ^{reg_wdata_i[6:2], reg_wdata_i[0]};
endmodule

// File: rtl/rst_src_ctrl_chk.sv
module rst_src_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ext_rst_ni,
  input logic       reg_we_i,
  input logic       reg_sel_i,
  input logic [7:0] reg_rdata_o,
  input logic       sys_rst_o,
  input logic       mon_en_q,
  input logic       mon_sel_q
);
  logic [1:0] pin_low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           pin_low_cnt <= '0;
    else if (ext_rst_ni)                   pin_low_cnt <= '0;
    else if (pin_low_cnt != 2'd3)          pin_low_cnt <= pin_low_cnt + 1'b1;
  end

  a_r1_pin_holds_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_low_cnt == 2'd3) |-> sys_rst_o);

  a_r3_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_sel_i |-> (reg_rdata_o[5:0] == 6'd0));

  a_r4_status_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_sel_i && reg_rdata_o[6]) |-> reg_rdata_o[7]);

  a_r8_flags_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_sel_i |-> ($onehot0({reg_rdata_o[4:2], reg_rdata_o[0]}) && reg_rdata_o[7:5] == 3'd0));

  a_r9_en_write_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && !reg_sel_i) |=> $stable(mon_en_q));

  a_r12_no_write_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_o && reg_we_i) |=> ($stable(mon_en_q) && $stable(mon_sel_q)));
endmodule

bind rst_src_ctrl rst_src_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ext_rst_ni (ext_rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_sel_i  (reg_sel_i),
  .reg_rdata_o(reg_rdata_o),
  .sys_rst_o  (sys_rst_o),
  .mon_en_q   (mon_en_q),
  .mon_sel_q  (mon_sel_q)
);

// File: tb/rst_src_ctrl_bench.sv
module rst_src_ctrl_bench;
  localparam int STRETCH = 16;
  localparam int SETTLE  = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ext_rst_ni = 1'b1;
  logic       vmon_cmp_i = 1'b0;
  logic       sw_rst_i = 1'b0;
  logic       reg_we_i = 1'b0;
  logic       reg_sel_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       sys_rst_o;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  rst_src_ctrl #(.STRETCH_CYC(STRETCH), .SETTLE_CYC(SETTLE)) u_rst_src_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .ext_rst_ni(ext_rst_ni), .vmon_cmp_i(vmon_cmp_i),
    .sw_rst_i(sw_rst_i), .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .sys_rst_o(sys_rst_o)
  );

  // behavioural reference: state 0 running, 1 held by source, 2 stretching
  int m_p1, m_p2, m_c1, m_c2, m_en, m_sel, m_scnt, m_state, m_cause, m_cnt, m_fl;

  function automatic int m_ok();
    return (m_en != 0 && m_scnt == SETTLE && m_c2 != 0) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_p1 = 1; m_p2 = 1; m_c1 = 0; m_c2 = 0; m_en = 0; m_sel = 0; m_scnt = 0;
      m_state = 2; m_cause = 'h10; m_cnt = 0; m_fl = 0;
    end else begin
      int ok, req, pin, inrst;
      ok = m_ok();
      req = (m_en != 0 && m_sel != 0 && ok == 0) ? 1 : 0;
      pin = (m_p2 == 0) ? 1 : 0;
      inrst = (m_state != 0) ? 1 : 0;
      if (m_en == 0) m_scnt = 0;
      else if (m_scnt < SETTLE) m_scnt++;
      if (m_state == 0) begin
        m_cnt = 0;
        if (pin != 0) begin m_state = 1; m_cause = 'h01; end
        else if (req != 0) begin m_state = 1; m_cause = 'h04; end
        else if (sw_rst_i) begin m_state = 2; m_cause = 'h08; end
      end else if (m_state == 1) begin
        m_cnt = 0;
        if (m_cause == 'h01) begin
          if (pin == 0) m_state = 2;
        end else if (pin != 0) m_cause = 'h01;
        else if (req == 0) begin m_state = 0; m_fl = m_cause; end
      end else begin
        if (pin != 0) begin m_state = 1; m_cause = 'h01; m_cnt = 0; end
        else if (m_cnt == STRETCH - 1) begin m_state = 0; m_fl = m_cause; end
        else m_cnt++;
      end
      if (reg_we_i && inrst == 0) begin
        if (!reg_sel_i) m_en = reg_wdata_i[7];
        else m_sel = reg_wdata_i[1];
      end
      m_p2 = m_p1; m_p1 = ext_rst_ni;
      m_c2 = m_c1; m_c1 = vmon_cmp_i;
    end
  end

  always @(negedge clk) begin
    int exp_rd;
    exp_rd = reg_sel_i ? (m_fl | (m_sel << 1)) : ((m_en << 7) | (m_ok() << 6));
    checks++;
    if (sys_rst_o !== (m_state != 0)) begin
      errors++;
      $display("FAIL R2 sys_rst model t=%0t act=%0d exp=%0d", $time, sys_rst_o, m_state != 0);
    end
    checks++;
    if (reg_rdata_o !== 8'(exp_rd)) begin
      errors++;
      $display("FAIL R8 rdata model t=%0t act=%02h exp=%02h", $time, reg_rdata_o, 8'(exp_rd));
    end
  end

  task automatic step(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    reg_sel_i = sel; reg_wdata_i = d; reg_we_i = 1'b1;
    step(1);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(logic sel, int exp, string tag);
    reg_sel_i = sel;
    #1;
    chk(tag, int'(reg_rdata_o), exp);
  endtask

  task automatic sw_pulse();
    sw_rst_i = 1'b1; step(1); sw_rst_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(3);
    chk("R2 reset state", sys_rst_o, 1);
    rst_ni = 1'b1;
    step(1);
    chk("R2 stretch after power-on", sys_rst_o, 1);
    step(STRETCH + 2);
    chk("R2 released", sys_rst_o, 0);
    rd(1, 'h10, "R8 power-on flag");
    rd(0, 'h00, "R3 monitor idle");

    wr(0, 8'h3F);
    rd(0, 'h00, "R3 reserved bits");

    ext_rst_ni = 1'b0; step(6);
    chk("R1 pin holds reset", sys_rst_o, 1);
    ext_rst_ni = 1'b1; step(4);
    chk("R2 pin stretch", sys_rst_o, 1);
    step(STRETCH + 2);
    chk("R2 pin released", sys_rst_o, 0);
    rd(1, 'h01, "R8 pin flag");

    sw_pulse();
    chk("R10 sw reset", sys_rst_o, 1);
    step(STRETCH + 2);
    chk("R10 sw released", sys_rst_o, 0);
    rd(1, 'h08, "R10 sw flag");

    wr(1, 8'h02); step(10);
    chk("R5 select without enable", sys_rst_o, 0);
    rd(1, 'h0A, "R5 select bit");
    wr(1, 8'h00);

    vmon_cmp_i = 1'b1;
    wr(0, 8'h80);
    rd(0, 'h80, "R4 unsettled status");
    step(SETTLE + 3);
    rd(0, 'hC0, "R4 settled status");
    vmon_cmp_i = 1'b0; step(3);
    rd(0, 'h80, "R3 status low");
    chk("R5 enabled not selected", sys_rst_o, 0);
    vmon_cmp_i = 1'b1; step(3);

    wr(1, 8'h02); step(5);
    chk("R6 safe select", sys_rst_o, 0);

    vmon_cmp_i = 1'b0; step(4);
    chk("R7 monitor reset", sys_rst_o, 1);
    vmon_cmp_i = 1'b1; step(3);
    chk("R7 fast release", sys_rst_o, 0);
    rd(1, 'h06, "R8 monitor flag");

    sw_pulse(); step(STRETCH + 3);
    rd(0, 'hC0, "R9 enable kept");
    rd(1, 'h0A, "R9 select kept");

    ext_rst_ni = 1'b0; step(4);
    wr(0, 8'h00); wr(1, 8'h00);
    ext_rst_ni = 1'b1; step(STRETCH + 5);
    rd(0, 'hC0, "R12 write in reset ignored");
    rd(1, 'h03, "R12 select unchanged");

    sw_rst_i = 1'b1; ext_rst_ni = 1'b0; step(1);
    sw_rst_i = 1'b0; step(3);
    ext_rst_ni = 1'b1; step(STRETCH + 5);
    rd(1, 'h03, "R11 pin over sw");

    sw_pulse(); step(4);
    ext_rst_ni = 1'b0; step(3);
    ext_rst_ni = 1'b1; step(STRETCH + 5);
    rd(1, 'h03, "R11 pin during stretch");

    rst_ni = 1'b0; step(2);
    rst_ni = 1'b1; step(STRETCH + 3);
    rd(0, 'h00, "R9 power-on clears enable");
    rd(1, 'h10, "R9 power-on clears select");

    wr(0, 8'h80); wr(1, 8'h02); step(2);
    chk("R6 early select resets", sys_rst_o, 1);
    step(SETTLE + 6);
    chk("R6 release after settle", sys_rst_o, 0);
    rd(1, 'h06, "R6 monitor flag");

    step(2);
    finish_run();
  end
endmodule